// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial master read and write a small bank of byte-wide registers over a four-wire serial link. The link has an active-low chip select, a serial clock, a master-to-slave data line and a slave-to-master data line. The bank holds `N_CTRL` writable control registers, whose values are driven out on a parallel port. It also holds `N_STAT` read-only status bytes, which are taken from a parallel input port. How the status bytes are produced, and what the control bytes mean, is up to the surrounding logic.

All three serial inputs are resynchronised into the faster system clock through two flops, and edges are found in that clock domain. Each received byte is decoded as a command unless it is the data byte of a write. Reads are pipelined. The byte addressed by a command is loaded into the output shifter at the falling clock edge that ends the command byte, and it leaves the device during the next byte, while the master shifts in its next command or filler. A write is held until chip select is released, and it takes effect only if that frame was exactly two bytes long.

The serial side runs at the pace the master sets, and there is no back-pressure. The parallel ports are plain levels with no valid/ready handshake. The status input is sampled at the moment a byte is loaded. Each serial clock phase must last at least four system clocks. Chip select must be stable for at least four system clocks before the first serial clock edge and after the last one.

Top module: `spi_regs_slave`

## Requirements
- R1: After reset, `spi_miso` and `spi_miso_valid` are 0 and every control byte on `ctrl_q` is 0x00.
- R2: A command byte uses bits [7:6] as the opcode (2'b00 read, 2'b10 write) and bits [4:0] as the register address. Opcodes 2'b01 and 2'b11 change neither the remembered address nor any register. Bits travel MSB first, are sampled on the rising serial clock edge and are changed on the falling edge.
- R3: The byte at the address named by a read command appears on `spi_miso` during the byte that follows it in the same frame. It is loaded at the falling edge of the eighth clock of the command.
- R4: While chip select stays low, every completed byte that is not write data is decoded as a fresh command, so reads can be chained without limit.
- R5: Until some read or write command has been received after reset, the device shifts out 0x00 with `spi_miso_valid` low. Once an address is known, `spi_miso_valid` stays high during selected frames.
- R6: A frame whose first byte is a write command to control address A (A < `N_CTRL`), and which holds exactly 16 serial clocks, writes its second byte into control register A when chip select rises.
- R7: A write frame with any other clock count (for example 15, 17 or 24) leaves every control register unchanged. So does a write command that is not the first byte of its frame.
- R8: A write aimed at a status address or an unmapped address leaves every control register unchanged.
- R9: At the start of every frame, and during the data byte of a write, the device shifts out the current contents of the most recently received address.
- R10: Reads of addresses 0..`N_CTRL`-1 return the control bytes without parity. Reads of `STAT_BASE`..`STAT_BASE`+`N_STAT`-1 return the matching byte of `stat_d`. Any other address returns 0x00, with `spi_miso_valid` still high.
- R11: `ctrl_q` does not change while chip select is low, even after the 16th clock of a valid write frame.
- R12: While chip select is high, `spi_miso` and `spi_miso_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select from the master, active low |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_valid | output | 1 | High when the byte being shifted out holds real register contents |
| stat_d | input | 8*N_STAT | Status bytes, byte j at bits [8j+7:8j] |
| ctrl_q | output | 8*N_CTRL | Control register bytes, byte i at bits [8i+7:8i] |

## Verification
The hardest situation to reach is one where the remembered address and the frame's write qualification disagree. Examples are a write command that arrives as the second byte of a chained frame, ignored opcodes placed between reads, and frames cut one clock short or run one clock long after a valid write. The bench builds each such frame bit by bit, with the bit count set separately from the byte list. Its model follows the address, the pending-data state and the first-byte flag through every byte. `ctrl_q` is compared on every system clock, including the window where a valid write has been fully clocked in but chip select is still low.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b10;

  typedef struct packed {
    logic [1:0]        op;
    logic              rsv;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q[i]    = s2;
    assign rise[i] = s2 & ~s3;
    assign fall[i] = ~s2 & s3;
  end
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
  import spi_regs_pkg::*;
#(
  parameter int FBW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [FBW-1:0]    frame_bits
);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);
  localparam logic [FBW-1:0] FB_MAX = '1;

  logic [BCW-1:0]    bit_cnt;
  logic [BYTE_W-2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      sh         <= '0;
      byte_done  <= 1'b0;
      rx_byte    <= '0;
      frame_bits <= '0;
    end else if (cs_start) begin
      bit_cnt    <= '0;
      byte_done  <= 1'b0;
      frame_bits <= '0;
    end else begin
      byte_done <= 1'b0;
      if (cs_act && sclk_rise) begin
        sh      <= {sh[BYTE_W-3:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (frame_bits != FB_MAX) frame_bits <= frame_bits + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          byte_done <= 1'b1;
          rx_byte   <= {sh, mosi_s};
        end
      end
    end
  end

  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done) else $error("byte_done held"); // R4
  AST_FRAME_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !cs_start) |=> (frame_bits >= $past(frame_bits))) else $error("frame_bits fell"); // R7
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_regs_pkg::*;
#(
  parameter int N_CTRL = 8,
  parameter int FBW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              cs_end,
  input  logic              sclk_fall,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [FBW-1:0]    frame_bits,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              miso,
  output logic              miso_valid,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [FBW-1:0]  WR_BITS  = FBW'(2 * BYTE_W);
  localparam logic [ADDR_W:0] CTRL_LIM = (ADDR_W + 1)'(N_CTRL);

  cmd_t              cmd;
  logic [ADDR_W-1:0] last_addr;
  logic              addr_known;
  logic              expect_data;
  logic              first_byte;
  logic              frame_wr;
  logic              load_pend;
  logic [BYTE_W-1:0] tx;
  logic              tx_valid;

  assign cmd     = cmd_t'(rx_byte);
  assign rd_addr = last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr   <= '0;
      addr_known  <= 1'b0;
      expect_data <= 1'b0;
      first_byte  <= 1'b1;
      frame_wr    <= 1'b0;
      load_pend   <= 1'b0;
      tx          <= '0;
      tx_valid    <= 1'b0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_start) begin
        first_byte  <= 1'b1;
        expect_data <= 1'b0;
        frame_wr    <= 1'b0;
        load_pend   <= 1'b0;
        tx          <= addr_known ? rd_data : '0;
        tx_valid    <= addr_known;
      end else if (cs_end) begin
        load_pend <= 1'b0;
        if (frame_wr && frame_bits == WR_BITS && {1'b0, wr_addr} < CTRL_LIM)
          wr_en <= 1'b1;
      end else if (byte_done) begin
        first_byte <= 1'b0;
        load_pend  <= 1'b1;
        if (expect_data) begin
          expect_data <= 1'b0;
          wr_data     <= rx_byte;
        end else if (cmd.op == OP_READ || cmd.op == OP_WRITE) begin
          last_addr  <= cmd.addr;
          addr_known <= 1'b1;
          if (cmd.op == OP_WRITE) begin
            expect_data <= 1'b1;
            if (first_byte) begin
              frame_wr <= 1'b1;
              wr_addr  <= cmd.addr;
            end
          end
        end
      end else if (cs_act && sclk_fall) begin
        if (load_pend) begin
          tx        <= addr_known ? rd_data : '0;
          tx_valid  <= addr_known;
          load_pend <= 1'b0;
        end else begin
          tx <= {tx[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso       = tx[BYTE_W-1] & cs_act;
  assign miso_valid = tx_valid & cs_act;

  AST_ZERO_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !tx_valid) |-> !tx[BYTE_W-1]) else $error("invalid data not zero"); // R5
  AST_WR_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cs_act) else $error("write while selected"); // R11
  AST_WR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(frame_bits) == WR_BITS)) else $error("write with wrong length"); // R7
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regs_pkg::*;
#(
  parameter int N_CTRL    = 8,
  parameter int N_STAT    = 4,
  parameter int STAT_BASE = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [N_STAT*BYTE_W-1:0] stat_d,
  output logic [BYTE_W-1:0]        rd_data,
  output logic [N_CTRL*BYTE_W-1:0] ctrl_q
);
  logic [BYTE_W-1:0] regs [N_CTRL];

  for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))     regs[i] <= wr_data;
    end
    assign ctrl_q[i*BYTE_W +: BYTE_W] = regs[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CTRL; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    for (int j = 0; j < N_STAT; j++)
      if (rd_addr == ADDR_W'(STAT_BASE + j)) rd_data = stat_d[j*BYTE_W +: BYTE_W];
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q)) else $error("control changed without write"); // R11
endmodule

// File: rtl/spi_regs_slave.sv
module spi_regs_slave
  import spi_regs_pkg::*;
#(
  parameter int N_CTRL    = 8,
  parameter int N_STAT    = 4,
  parameter int STAT_BASE = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_cs_n,
  input  logic                     spi_sclk,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  output logic                     spi_miso_valid,
  input  logic [N_STAT*BYTE_W-1:0] stat_d,
  output logic [N_CTRL*BYTE_W-1:0] ctrl_q
);
  localparam int FBW = $clog2(2 * BYTE_W) + 2;

  logic [2:0] pin_q, pin_rise, pin_fall;
  logic cs_act;
  logic byte_done;
  logic [BYTE_W-1:0] rx_byte, rd_data, wr_data;
  logic [FBW-1:0] frame_bits;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic wr_en;

  spi_sync_edge #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({spi_cs_n, spi_sclk, spi_mosi}),
    .q(pin_q), .rise(pin_rise), .fall(pin_fall)
  );

  assign cs_act = ~pin_q[2];

  spi_rx_frame #(.FBW(FBW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_act(cs_act), .cs_start(pin_fall[2]),
    .sclk_rise(pin_rise[1]), .mosi_s(pin_q[0]),
    .byte_done(byte_done), .rx_byte(rx_byte), .frame_bits(frame_bits)
  );

  spi_cmd_ctrl #(.N_CTRL(N_CTRL), .FBW(FBW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_act(cs_act), .cs_start(pin_fall[2]), .cs_end(pin_rise[2]),
    .sclk_fall(pin_fall[1]),
    .byte_done(byte_done), .rx_byte(rx_byte), .frame_bits(frame_bits),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .miso(spi_miso), .miso_valid(spi_miso_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  spi_reg_bank #(.N_CTRL(N_CTRL), .N_STAT(N_STAT), .STAT_BASE(STAT_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .stat_d(stat_d),
    .rd_data(rd_data), .ctrl_q(ctrl_q)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
      |-> !spi_miso && !spi_miso_valid) else $error("output while idle"); // R12
endmodule

// File: tb/spi_regs_slave_tb.sv
module spi_regs_slave_tb;
  localparam int NC = 8, NS = 4, SB = 16, H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_v;
  logic [NS*8-1:0] stat = '0;
  logic [NC*8-1:0] ctrl;

  always #2 clk = ~clk;

  spi_regs_slave #(.N_CTRL(NC), .N_STAT(NS), .STAT_BASE(SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_valid(miso_v), .stat_d(stat), .ctrl_q(ctrl)
  );

  int compared = 0, mismatched = 0;
  int clk_cmp = 0, clk_bad = 0;
  int cyc = 0, quiet_until = 1000000;
  bit finished = 0;

  logic [7:0] m_ctrl [NC];
  logic [4:0] m_last = '0;
  bit         m_known = 0;

  function automatic logic [NC*8-1:0] m_flat();
    logic [NC*8-1:0] f;
    for (int i = 0; i < NC; i++) f[i*8 +: 8] = m_ctrl[i];
    return f;
  endfunction

  function automatic logic [7:0] m_val(input logic [4:0] a);
    if (a < NC) return m_ctrl[a];
    if (a >= SB && a < SB + NS) return stat[(a - SB)*8 +: 8];
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && cyc >= quiet_until) begin
      clk_cmp++;
      if (ctrl !== m_flat()) begin
        clk_bad++;
        $display("FAIL R11 ctrl_q cycle %0d actual %h expected %h", cyc, ctrl, m_flat());
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bytes packed MSB-first: byte i at [63-8i -: 8]
  task automatic spi_xfer(input logic [63:0] bytes, input int nbits, input string tag);
    logic [7:0] exp_out, cb, wdat;
    logic [4:0] waddr;
    bit exp_v, first, expd, fwr;
    first = 1; expd = 0; fwr = 0; waddr = '0; wdat = '0;
    exp_out = m_known ? m_val(m_last) : 8'h00;
    exp_v = m_known;
    cs_n = 1'b0;
    wclk(H);
    for (int b = 0; b < nbits; b++) begin
      int bi, bp;
      bi = b / 8; bp = 7 - (b % 8);
      cb = (bi < 8) ? bytes[63 - 8*bi -: 8] : 8'h00;
      mosi = cb[bp];
      wclk(H);
      check(miso === exp_out[bp] && miso_v === exp_v, tag,
            {62'd0, miso_v, miso}, {62'd0, exp_v, exp_out[bp]});
      sclk = 1'b1;
      wclk(H);
      sclk = 1'b0;
      if (bp == 0) begin
        if (expd) begin
          expd = 0; wdat = cb;
        end else if (cb[7:6] == 2'b00 || cb[7:6] == 2'b10) begin
          m_last = cb[4:0]; m_known = 1;
          if (cb[7:6] == 2'b10) begin
            expd = 1;
            if (first) begin fwr = 1; waddr = cb[4:0]; end
          end
        end
        first = 0;
        exp_out = m_known ? m_val(m_last) : 8'h00;
        exp_v = m_known;
      end
    end
    wclk(H);
    if (fwr && nbits == 16 && waddr < NC) m_ctrl[waddr] = wdat;
    quiet_until = cyc + 10;
    cs_n = 1'b1;
    mosi = 1'b0;
    wclk(H);
    check(miso === 1'b0 && miso_v === 1'b0, "R12", {62'd0, miso_v, miso}, 64'd0);
    wclk(8);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) m_ctrl[i] = 8'h00;
    stat = {8'h5A, 8'h81, 8'h3C, 8'hE7};
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    quiet_until = cyc;
    check(miso === 1'b0 && miso_v === 1'b0, "R1", {62'd0, miso_v, miso}, 64'd0);
    check(ctrl === '0, "R1", 64'(ctrl), 64'd0);

    // first frame after reset: placeholder, then write commit (R5, R6, R9)
    spi_xfer({8'h82, 8'hA5, 48'd0}, 16, "R5");
    check(ctrl[2*8 +: 8] === 8'hA5, "R6", 64'(ctrl[2*8 +: 8]), 64'hA5);
    spi_xfer({8'h85, 8'h3C, 48'd0}, 16, "R9");
    spi_xfer({8'h87, 8'hFF, 48'd0}, 16, "R6");
    check(ctrl[7*8 +: 8] === 8'hFF, "R6", 64'(ctrl[7*8 +: 8]), 64'hFF);

    // chained reads across ctrl, status, unmapped (R3, R4, R10)
    spi_xfer({8'h02, 8'h05, 8'h10, 8'h13, 8'h09, 8'h1F, 8'h07, 8'h00}, 64, "R3");
    spi_xfer({8'h12, 8'h11, 8'h00, 40'd0}, 24, "R10");

    // wrong lengths (R7)
    spi_xfer({8'h83, 8'h11, 48'd0}, 15, "R7");
    spi_xfer({8'h83, 8'h22, 48'd0}, 17, "R7");
    spi_xfer({8'h83, 8'h33, 8'h44, 40'd0}, 24, "R7");
    spi_xfer({8'h00, 8'h81, 8'h77, 40'd0}, 24, "R7");
    check(ctrl[3*8 +: 8] === 8'h00 && ctrl[1*8 +: 8] === 8'h00, "R7",
          64'(ctrl[8 +: 24]), 64'd0);

    // writes to status / unmapped addresses (R8)
    spi_xfer({8'h91, 8'hEE, 48'd0}, 16, "R8");
    spi_xfer({8'h9D, 8'hEE, 48'd0}, 16, "R8");
    check(ctrl === m_flat(), "R8", 64'(ctrl), 64'(m_flat()));

    // ignored opcodes keep the address (R2)
    spi_xfer({8'h05, 8'h43, 8'hC1, 8'hE2, 8'h00, 24'd0}, 40, "R2");

    // status change observed at load time (R10)
    stat = {8'h01, 8'h02, 8'h03, 8'h04};
    spi_xfer({8'h11, 8'h13, 8'h00, 40'd0}, 24, "R10");

    // overwrite then read back (R6, R3)
    spi_xfer({8'h80, 8'h69, 48'd0}, 16, "R6");
    spi_xfer({8'h00, 8'h00, 48'd0}, 16, "R3");
    check(ctrl === m_flat(), "R6", 64'(ctrl), 64'(m_flat()));

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             compared + clk_cmp, mismatched + clk_bad);
    $finish;
  end
endmodule